// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers eight interrupt request lines into one interrupt output for a processor. Each line is captured into a request register. Capture follows the level of the line or its rising edge, chosen separately for each line. A mask register hides lines from arbitration. A fixed-priority resolver picks the best eligible line, with line 0 the most urgent and line 7 the least. An in-service register tracks the levels the processor is currently handling, so interrupts nest. A level is eligible only while it outranks every level already in service.

Software programs the block through a small register file on an 8-bit bus. The bus has an active-low select and active-low read and write strobes. On a one-cycle acknowledge pulse, the block moves the winning request into service and places a vector byte on the data bus. Software ends a service routine by writing a non-specific end-of-interrupt command.

Top module: `vic_core`

## Requirements
- R1: After reset, int_o is low, the mask register reads 0xFF (all lines hidden), every line is level-triggered, the request and in-service registers read 0x00, and the vector base is zero.
- R2: A register is written once per falling edge of wr_ni while cs_ni is low, and never while cs_ni is high. While cs_ni and rd_ni are both low, data_o returns the register at addr_i: 0 mask, 1 trigger mode (bit n = 1 makes line n edge-triggered), 2 in-service, 3 request.
- R3: An edge-triggered line sets its request bit on a rising edge of irq_i and holds it after the input falls, until the line is granted.
- R4: On a level-triggered line the request bit follows irq_i one cycle later. A request that falls before acknowledge is lost.
- R5: A set mask bit keeps its line from raising int_o, but the line is still recorded in the request register.
- R6: int_o is high exactly when some unmasked pending line has a lower index than every set in-service bit. Lines are ranked by index, with 0 the highest.
- R7: On an acknowledge pulse with int_o high, the lowest-index eligible line gets its in-service bit set and its request bit cleared. The vector {base[4:0], line[2:0]} then appears on data_o while no read is in progress. The base is written as bits 7:3 of register 3.
- R8: A set in-service bit blocks requests of equal and lower priority until it is cleared, and it does not block higher-priority requests.
- R9: Writing 0x20 to register 2 clears only the lowest-index set in-service bit.
- R10: An acknowledge with no eligible request returns {base, 3'd7} and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, line 0 highest priority |
| cs_ni | input | 1 | Register file select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low; acts on its falling edge |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data during a read, otherwise the last vector |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | One-cycle acknowledge pulse |

## Verification
Two edge pulses on lines 2 and 5 that fall before acknowledge show that edge requests are held (R3) and resolved by index (R7). A higher line raised while a lower one is in service shows that nesting opens upward only (R8). Two end-of-interrupt commands then unwind the nest one level at a time (R9). A level request that drops before acknowledge must give the spurious vector (R4, R10). A level request held through its own service must stay blocked until end-of-interrupt (R8). A masked line shows up in the request register but not on int_o (R5). A write with select high must leave the registers unchanged (R2).

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_MODE = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_BASE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] CMD_NS_EOI = 8'h20;
endpackage

// File: rtl/vic_bus.sv
module vic_bus
  import vic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3,
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [N_LINES-1:0] irr_i,
  input  logic [DATA_W-1:0]  vec_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] mode_o,
  output logic [BASE_W-1:0]  base_o,
  output logic               eoi_o,
  output logic [DATA_W-1:0]  data_o
);
  logic wr_q, wr_stb;
  logic [DATA_W-1:0] rd_mux;

  // one write per falling strobe edge
  assign wr_stb = !cs_ni && !wr_ni && wr_q;
  assign eoi_o  = wr_stb && (reg_sel_e'(addr_i) == SEL_CMD) && (data_i == CMD_NS_EOI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b1;
      mask_o <= '1;
      mode_o <= '0;
      base_o <= '0;
    end else begin
      wr_q <= wr_ni | cs_ni;
      if (wr_stb) begin
        case (reg_sel_e'(addr_i))
          SEL_MASK: mask_o <= data_i[N_LINES-1:0];
          SEL_MODE: mode_o <= data_i[N_LINES-1:0];
          SEL_BASE: base_o <= data_i[DATA_W-1:IDX_W];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(addr_i))
      SEL_MASK: rd_mux[N_LINES-1:0] = mask_o;
      SEL_MODE: rd_mux[N_LINES-1:0] = mode_o;
      SEL_CMD:  rd_mux[N_LINES-1:0] = isr_i;
      default:  rd_mux[N_LINES-1:0] = irr_i;
    endcase
  end

  assign data_o = (!cs_ni && !rd_ni) ? rd_mux : vec_i;
endmodule

// File: rtl/vic_req.sv
module vic_req #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] mode_i,
  input  logic [N_LINES-1:0] grant_i,
  output logic [N_LINES-1:0] irr_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic irq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q    <= 1'b0;
        irr_o[i] <= 1'b0;
      end else begin
        irq_q <= irq_i[i];
        if (mode_i[i])
          irr_o[i] <= (irr_o[i] | (irq_i[i] & ~irq_q)) & ~grant_i[i];
        else
          irr_o[i] <= irq_i[i] & ~grant_i[i];
      end
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  output logic               req_o,
  output logic [N_LINES-1:0] win_oh_o,
  output logic [IDX_W-1:0]   win_idx_o
);
  logic [N_LINES-1:0] pend, isr_top, allow, elig;

  assign pend     = irr_i & ~mask_i;
  assign isr_top  = isr_i & (~isr_i + 1'b1);
  // only levels strictly above the top in-service level
  assign allow    = (isr_i == '0) ? '1 : isr_top - 1'b1;
  assign elig     = pend & allow;
  assign win_oh_o = elig & (~elig + 1'b1);
  assign req_o    = |elig;

  always_comb begin
    win_idx_o = '0;
    for (int i = 0; i < N_LINES; i++)
      if (win_oh_o[i]) win_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/vic_core.sv
module vic_core #(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               int_o,
  input  logic               inta_i
);
  logic [N_LINES-1:0] mask_q, mode_q, irr_q, isr_q, win_oh, grant, eoi_clr;
  logic [BASE_W-1:0]  base_q;
  logic [IDX_W-1:0]   win_idx;
  logic [DATA_W-1:0]  vec_q;
  logic               eoi_w, req_w;

  vic_bus #(.N_LINES(N_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bus (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .isr_i(isr_q), .irr_i(irr_q), .vec_i(vec_q),
    .mask_o(mask_q), .mode_o(mode_q), .base_o(base_q), .eoi_o(eoi_w), .data_o
  );

  vic_req #(.N_LINES(N_LINES)) u_req (
    .clk_i, .rst_ni, .irq_i, .mode_i(mode_q), .grant_i(grant), .irr_o(irr_q)
  );

  vic_prio #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_prio (
    .irr_i(irr_q), .mask_i(mask_q), .isr_i(isr_q),
    .req_o(req_w), .win_oh_o(win_oh), .win_idx_o(win_idx)
  );

  assign int_o   = req_w;
  assign grant   = (inta_i && req_w) ? win_oh : '0;
  assign eoi_clr = eoi_w ? (isr_q & (~isr_q + 1'b1)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | grant;
      if (inta_i)
        vec_q <= req_w ? {base_q, win_idx} : {base_q, IDX_W'(N_LINES - 1)};
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               int_o,
  input logic               ack_i,
  input logic               eoi_i,
  input logic [N_LINES-1:0] irr_i,
  input logic [N_LINES-1:0] mask_i,
  input logic [N_LINES-1:0] isr_i
);
  // R6
  int_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_i & ~mask_i) != '0));

  // R7
  grant_adds_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !eoi_i) |=> ($countones(isr_i) == $countones($past(isr_i)) + 1));

  // R8
  no_grant_no_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((isr_i & ~$past(isr_i)) == '0));

  // R9
  eoi_drops_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (isr_i != '0)) |=> ($countones(isr_i) + 1 == $countones($past(isr_i))));

  // R10
  spurious_keeps_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !eoi_i) |=> (isr_i == $past(isr_i)));
endmodule

bind vic_core vic_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_o(int_o), .ack_i(inta_i), .eoi_i(eoi_w),
  .irr_i(irr_q), .mask_i(mask_q), .isr_i(isr_q)
);

// File: tb/tb_vic_core.sv
module tb_vic_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] irq = '0, wdata = '0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, inta = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data_o;
  logic       int_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(wdata), .data_o(data_o), .int_o(int_o), .inta_i(inta)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1 chk(data_o, exp, tag);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic int_chk(input logic exp, input string tag);
    @(negedge clk); #1 chk({7'd0, int_o}, {7'd0, exp}, tag);
  endtask

  task automatic ack_chk(input logic [7:0] exp, input string tag);
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
    #1 chk(data_o, exp, tag);
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk); irq = irq | lines;
    @(negedge clk); irq = irq & ~lines;
  endtask

  task automatic t_reset;
    int_chk(1'b0, "R1 int_o after reset");
    rd_chk(2'd0, 8'hFF, "R1 mask after reset");
    rd_chk(2'd1, 8'h00, "R1 mode after reset");
    rd_chk(2'd2, 8'h00, "R1 isr after reset");
    rd_chk(2'd3, 8'h00, "R1 irr after reset");
  endtask

  task automatic t_bus;
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd0; wdata = 8'h00;
    @(negedge clk); wr_n = 1;
    rd_chk(2'd0, 8'hFF, "R2 write ignored with select high");
    wr_reg(2'd3, 8'h80);
    ack_chk(8'h87, "R2 R10 base written, spurious vector");
    rd_chk(2'd2, 8'h00, "R10 isr unchanged on spurious");
  endtask

  task automatic t_mask;
    @(negedge clk); irq = 8'h08;
    int_chk(1'b0, "R5 masked line no int");
    rd_chk(2'd3, 8'h08, "R5 masked line still in irr");
    wr_reg(2'd0, 8'h00);
    int_chk(1'b1, "R6 unmasked line raises int");
    irq = 8'h00;
    int_chk(1'b0, "R4 level request drops");
  endtask

  task automatic t_edge_nest;
    wr_reg(2'd1, 8'hFF);
    pulse(8'h24);
    rd_chk(2'd3, 8'h24, "R3 edge requests held after input falls");
    ack_chk(8'h82, "R7 line 2 wins over 5");
    rd_chk(2'd2, 8'h04, "R7 isr bit 2 set");
    rd_chk(2'd3, 8'h20, "R7 irr bit 2 cleared");
    int_chk(1'b0, "R8 lower line blocked");
    pulse(8'h02);
    int_chk(1'b1, "R8 higher line passes");
    ack_chk(8'h81, "R7 nested vector line 1");
    rd_chk(2'd2, 8'h06, "R8 nested isr");
    wr_reg(2'd2, 8'h20);
    rd_chk(2'd2, 8'h04, "R9 eoi clears line 1 only");
    int_chk(1'b0, "R8 line 5 still blocked");
    wr_reg(2'd2, 8'h20);
    int_chk(1'b1, "R9 line 5 reopened");
    ack_chk(8'h85, "R7 vector line 5");
    rd_chk(2'd3, 8'h00, "R7 irr empty");
    wr_reg(2'd2, 8'h20);
    rd_chk(2'd2, 8'h00, "R9 isr empty");
  endtask

  task automatic t_level;
    wr_reg(2'd1, 8'h00);
    @(negedge clk); irq = 8'h10;
    int_chk(1'b1, "R4 level request seen");
    irq = 8'h00;
    int_chk(1'b0, "R4 level request gone");
    ack_chk(8'h87, "R4 R10 lost request gives spurious");
    rd_chk(2'd2, 8'h00, "R10 isr unchanged");
    @(negedge clk); irq = 8'h08;
    int_chk(1'b1, "R6 level line 3");
    ack_chk(8'h83, "R7 vector line 3");
    rd_chk(2'd3, 8'h08, "R4 held level reloads irr");
    int_chk(1'b0, "R8 equal level blocked");
    wr_reg(2'd2, 8'h20);
    int_chk(1'b1, "R9 equal level reopened");
    irq = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset;
    t_bus;
    t_mask;
    t_edge_nest;
    t_level;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule